// File: doc/BRIEF.md
# Basic-Rate Line Frame Assembler and Sync Detector

This block sits between a quaternary symbol encoder and a line transmitter. Its input is a symbol-rate enable. It emits a 120-symbol line frame that has three parts in this order: a 9-symbol framing word, 108 payload symbols that it pulls from the upstream encoder through a request strobe, and 3 maintenance symbols. Eight frames make one superframe, and the first frame of each superframe carries the framing word with every polarity flipped.

On the receive side the block searches the incoming symbol stream for either framing word. It declares frame lock once the word has been seen at the same position in two consecutive frames. It keeps lock until three frames in a row miss the word. After the flipped word has been seen while locked, the block has superframe alignment, and only then does it strobe out payload slots. In network-terminal mode the transmit frame is slaved to the received one and lags it by a fixed 60 symbols. In line-terminal mode the transmit frame runs free from reset.

Top module: `ubr_framer`

## Requirements
- R1: A frame is 120 symbols. `tx_frame` is high for exactly one symbol period in every 120, and that symbol is the first symbol of the frame. All outputs are low after reset.
- R2: Symbols are 2-bit codes {sign, magnitude}: 2'b10 = +3, 2'b11 = +1, 2'b01 = -1, 2'b00 = -3. Frame symbols 0..8 carry the framing word +3,+3,-3,-3,-3,+3,-3,+3,+3 in that order.
- R3: `tx_superframe` is high for the first symbol of every eighth frame. The framing word of that frame has every sign inverted (-3,-3,+3,+3,+3,-3,+3,-3,-3).
- R4: `pl_req` is high only in symbol-enable cycles for frame symbols 9..116, which gives 108 strobes per frame. The `pl_sym` value present in that cycle appears on `tx_sym` for that symbol.
- R5: Frame symbols 117..119 carry the `maint_sym` value present in their symbol-enable cycle.
- R6: `rx_locked` rises only after either framing word has been received at the same frame position in two consecutive frames. A single occurrence does not set it.
- R7: Once locked, `rx_locked` falls only after three consecutive frames lack the framing word. A hit clears the count of misses.
- R8: `rx_sf_locked` is set when the inverted word is received while locked, and it clears when lock is lost. `rx_pl_valid` strobes only while `rx_sf_locked` is high, once for each received frame symbol 9..116.
- R9: With `nt_mode` high and superframe alignment held, the transmitted superframe starts exactly 60 symbols after the first symbol of the received superframe.
- R10: With `nt_mode` low, the first symbol sent after reset is symbol 0 of a superframe's first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_tick | input | 1 | Symbol-rate enable, one cycle per symbol |
| nt_mode | input | 1 | High: transmit framing follows receive framing |
| pl_sym | input | 2 | Payload symbol from encoder, taken when pl_req is high |
| maint_sym | input | 2 | Maintenance symbol for the frame tail |
| pl_req | output | 1 | Payload symbol request strobe |
| tx_sym | output | 2 | Transmit symbol, held between enables |
| tx_frame | output | 1 | High while the first symbol of a frame is on tx_sym |
| tx_superframe | output | 1 | High while the first symbol of a superframe is on tx_sym |
| rx_sym | input | 2 | Received symbol, taken on sym_tick |
| rx_locked | output | 1 | Receive frame lock |
| rx_sf_locked | output | 1 | Receive superframe alignment |
| rx_pl_valid | output | 1 | Received symbol in this enable cycle is payload |

## Verification
The hardest condition to reach is the network-terminal alignment. It needs a receive lock, then an inverted word that arrives while locked, and after that a full superframe at the aligned phase. Only then can the 60-symbol lag be measured against a clean boundary. The bench builds its own line stream and starts it at an arbitrary phase. It runs one full superframe to acquire alignment, then times the transmit superframe marker against the first symbol of the next received superframe. The loss rules are reached with frames whose framing word has been replaced by +1 symbols, interleaved with good frames, so that the miss count is seen both to reset and to expire.

// File: rtl/ubr_pkg.sv
package ubr_pkg;
  typedef logic [1:0] quat_t;

  localparam int SYNC_LEN = 9;
  // sign bits of the framing word, first symbol at the MSB
  localparam logic [SYNC_LEN-1:0] SW_SIGNS = 9'b110001011;

  typedef enum logic [1:0] {RX_HUNT, RX_CHECK, RX_LOCK} rx_state_e;

  // framing symbols are always magnitude 3, so only the sign varies
  function automatic quat_t sync_quat(input logic [3:0] idx, input logic inv);
    logic s;
    s = SW_SIGNS[4'(SYNC_LEN-1) - idx] ^ inv;
    return {s, 1'b0};
  endfunction

  function automatic logic [2*SYNC_LEN-1:0] sync_window(input logic inv);
    logic [2*SYNC_LEN-1:0] w;
    w = '0;
    for (int i = 0; i < SYNC_LEN; i++)
      w[2*(SYNC_LEN-1-i) +: 2] = sync_quat(4'(i), inv);
    return w;
  endfunction
endpackage

// File: rtl/ubr_tx_seq.sv
module ubr_tx_seq
  import ubr_pkg::*;
#(
  parameter int PAYLOAD_SYMS  = 108,
  parameter int MAINT_SYMS    = 3,
  parameter int FRAMES_PER_SF = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sym_tick,
  input  logic  align,
  input  quat_t pl_sym,
  input  quat_t maint_sym,
  output logic  pl_req,
  output quat_t tx_sym,
  output logic  tx_fs,
  output logic  tx_sf
);
  localparam int FRAME_SYMS = SYNC_LEN + PAYLOAD_SYMS + MAINT_SYMS;
  localparam int POS_W = $clog2(FRAME_SYMS);
  localparam int FRM_W = $clog2(FRAMES_PER_SF);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_SYMS - 1);
  localparam logic [POS_W-1:0] PL_FIRST = POS_W'(SYNC_LEN);
  localparam logic [POS_W-1:0] MT_FIRST = POS_W'(SYNC_LEN + PAYLOAD_SYMS);
  localparam logic [FRM_W-1:0] FRM_LAST = FRM_W'(FRAMES_PER_SF - 1);

  logic [POS_W-1:0] pos_q, pos_nx, eff_pos;
  logic [FRM_W-1:0] frm_q, frm_nx, eff_frm;
  quat_t            sym_q, sym_nx, sel;
  logic             fs_q, fs_nx, sf_q, sf_nx;
  logic             in_sync, in_pl;

  always_comb begin
    eff_pos = align ? '0 : pos_q;
    eff_frm = align ? '0 : frm_q;
    in_sync = eff_pos < PL_FIRST;
    in_pl   = !in_sync && (eff_pos < MT_FIRST);
    if (in_sync)    sel = sync_quat(4'(eff_pos), eff_frm == '0);
    else if (in_pl) sel = pl_sym;
    else            sel = maint_sym;

    pos_nx = pos_q;
    frm_nx = frm_q;
    sym_nx = sym_q;
    fs_nx  = fs_q;
    sf_nx  = sf_q;
    if (sym_tick) begin
      sym_nx = sel;
      fs_nx  = (eff_pos == '0);
      sf_nx  = (eff_pos == '0) && (eff_frm == '0);
      if (eff_pos == POS_LAST) begin
        pos_nx = '0;
        frm_nx = (eff_frm == FRM_LAST) ? '0 : eff_frm + 1'b1;
      end else begin
        pos_nx = eff_pos + 1'b1;
        frm_nx = eff_frm;
      end
    end
  end

  assign pl_req = sym_tick && in_pl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      frm_q <= '0;
      sym_q <= '0;
      fs_q  <= 1'b0;
      sf_q  <= 1'b0;
    end else begin
      pos_q <= pos_nx;
      frm_q <= frm_nx;
      sym_q <= sym_nx;
      fs_q  <= fs_nx;
      sf_q  <= sf_nx;
    end
  end

  assign tx_sym = sym_q;
  assign tx_fs  = fs_q;
  assign tx_sf  = sf_q;

  a_r3_sf_in_fs: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sf |-> tx_fs);
  a_r3_isw_lead: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sf |-> tx_sym == 2'b00);
  a_r2_sw_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fs && !tx_sf) |-> tx_sym == 2'b10);
  a_r4_req_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pl_req |-> sym_tick);
  a_r1_marker_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_tick |=> $stable(tx_fs));
endmodule

// File: rtl/ubr_rx_sync.sv
module ubr_rx_sync
  import ubr_pkg::*;
#(
  parameter int PAYLOAD_SYMS  = 108,
  parameter int MAINT_SYMS    = 3,
  parameter int FRAMES_PER_SF = 8,
  parameter int LOCK_HITS     = 2,
  parameter int LOSS_MISSES   = 3,
  parameter int LAG_POS       = 60
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sym_tick,
  input  quat_t rx_sym,
  output logic  locked,
  output logic  sf_locked,
  output logic  pl_valid,
  output logic  lag_hit
);
  localparam int FRAME_SYMS = SYNC_LEN + PAYLOAD_SYMS + MAINT_SYMS;
  localparam int POS_W  = $clog2(FRAME_SYMS);
  localparam int FRM_W  = $clog2(FRAMES_PER_SF);
  localparam int HIST_W = 2 * (SYNC_LEN - 1);
  localparam int HW     = $clog2(LOCK_HITS + 1);
  localparam int MW     = $clog2(LOSS_MISSES + 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_SYMS - 1);
  localparam logic [POS_W-1:0] POS_CHK  = POS_W'(SYNC_LEN - 1);
  localparam logic [POS_W-1:0] PL_FIRST = POS_W'(SYNC_LEN);
  localparam logic [POS_W-1:0] MT_FIRST = POS_W'(SYNC_LEN + PAYLOAD_SYMS);
  localparam logic [POS_W-1:0] POS_LAG  = POS_W'(LAG_POS);
  localparam logic [FRM_W-1:0] FRM_LAST = FRM_W'(FRAMES_PER_SF - 1);
  localparam logic [2*SYNC_LEN-1:0] WIN_SW  = sync_window(1'b0);
  localparam logic [2*SYNC_LEN-1:0] WIN_ISW = sync_window(1'b1);

  rx_state_e        state_q, state_nx;
  logic [HIST_W-1:0] hist_q, hist_nx;
  logic [POS_W-1:0] pos_q, pos_nx;
  logic [FRM_W-1:0] frm_q, frm_nx;
  logic [HW-1:0]    hits_q, hits_nx;
  logic [MW-1:0]    miss_q, miss_nx;
  logic             sfl_q, sfl_nx;
  logic [2*SYNC_LEN-1:0] window;
  logic             m_sw, m_isw, hit, at_check;

  always_comb begin
    window   = {hist_q, rx_sym};
    m_sw     = (window == WIN_SW);
    m_isw    = (window == WIN_ISW);
    hit      = m_sw || m_isw;
    at_check = (pos_q == POS_CHK);

    state_nx = state_q;
    hist_nx  = hist_q;
    pos_nx   = pos_q;
    frm_nx   = frm_q;
    hits_nx  = hits_q;
    miss_nx  = miss_q;
    sfl_nx   = sfl_q;
    if (sym_tick) begin
      hist_nx = window[HIST_W-1:0];
      if (pos_q == POS_LAST) begin
        pos_nx = '0;
        frm_nx = (frm_q == FRM_LAST) ? '0 : frm_q + 1'b1;
      end else begin
        pos_nx = pos_q + 1'b1;
      end
      unique case (state_q)
        RX_HUNT: if (hit) begin
          pos_nx   = PL_FIRST;
          hits_nx  = HW'(1);
          state_nx = RX_CHECK;
          if (m_isw) frm_nx = '0;
        end
        RX_CHECK: if (at_check) begin
          if (hit) begin
            hits_nx = hits_q + 1'b1;
            if (m_isw) frm_nx = '0;
            if (hits_q + 1'b1 == HW'(LOCK_HITS)) begin
              state_nx = RX_LOCK;
              miss_nx  = '0;
              sfl_nx   = m_isw;
            end
          end else begin
            state_nx = RX_HUNT;
          end
        end
        default: if (at_check) begin
          if (hit) begin
            miss_nx = '0;
            if (m_isw) begin
              frm_nx = '0;
              sfl_nx = 1'b1;
            end
          end else if (miss_q + 1'b1 == MW'(LOSS_MISSES)) begin
            state_nx = RX_HUNT;
            miss_nx  = '0;
            sfl_nx   = 1'b0;
          end else begin
            miss_nx = miss_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_HUNT;
      hist_q  <= '0;
      pos_q   <= '0;
      frm_q   <= '0;
      hits_q  <= '0;
      miss_q  <= '0;
      sfl_q   <= 1'b0;
    end else begin
      state_q <= state_nx;
      hist_q  <= hist_nx;
      pos_q   <= pos_nx;
      frm_q   <= frm_nx;
      hits_q  <= hits_nx;
      miss_q  <= miss_nx;
      sfl_q   <= sfl_nx;
    end
  end

  assign locked    = (state_q == RX_LOCK);
  assign sf_locked = sfl_q;
  assign pl_valid  = sym_tick && sfl_q && (pos_q >= PL_FIRST) && (pos_q < MT_FIRST);
  assign lag_hit   = sym_tick && sfl_q && (pos_q == POS_LAG) && (frm_q == '0);

  a_r6_lock_via_check: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(state_q) == RX_CHECK);
  a_r7_loss_after_misses: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(miss_q) == MW'(LOSS_MISSES - 1));
  a_r8_sf_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    sf_locked |-> locked);
  a_r8_pl_needs_sf: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid |-> sf_locked);
endmodule

// File: rtl/ubr_framer.sv
module ubr_framer
  import ubr_pkg::*;
#(
  parameter int PAYLOAD_SYMS  = 108,
  parameter int MAINT_SYMS    = 3,
  parameter int FRAMES_PER_SF = 8,
  parameter int LOCK_HITS     = 2,
  parameter int LOSS_MISSES   = 3,
  parameter int NT_LAG        = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_tick,
  input  logic       nt_mode,
  input  logic [1:0] pl_sym,
  input  logic [1:0] maint_sym,
  output logic       pl_req,
  output logic [1:0] tx_sym,
  output logic       tx_frame,
  output logic       tx_superframe,
  input  logic [1:0] rx_sym,
  output logic       rx_locked,
  output logic       rx_sf_locked,
  output logic       rx_pl_valid
);
  logic lag_hit, align;

  assign align = nt_mode && lag_hit;

  ubr_tx_seq #(
    .PAYLOAD_SYMS(PAYLOAD_SYMS), .MAINT_SYMS(MAINT_SYMS), .FRAMES_PER_SF(FRAMES_PER_SF)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .sym_tick(sym_tick), .align(align),
    .pl_sym(pl_sym), .maint_sym(maint_sym), .pl_req(pl_req),
    .tx_sym(tx_sym), .tx_fs(tx_frame), .tx_sf(tx_superframe)
  );

  ubr_rx_sync #(
    .PAYLOAD_SYMS(PAYLOAD_SYMS), .MAINT_SYMS(MAINT_SYMS), .FRAMES_PER_SF(FRAMES_PER_SF),
    .LOCK_HITS(LOCK_HITS), .LOSS_MISSES(LOSS_MISSES), .LAG_POS(NT_LAG)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .sym_tick(sym_tick), .rx_sym(rx_sym),
    .locked(rx_locked), .sf_locked(rx_sf_locked), .pl_valid(rx_pl_valid),
    .lag_hit(lag_hit)
  );

  a_r9_align_in_sf: assert property (@(posedge clk) disable iff (!rst_n)
    align |=> tx_superframe);
endmodule

// File: tb/sim_ubr_framer.sv
module sim_ubr_framer;
  logic clk = 1'b0;
  logic rst_n, sym_tick, nt_mode;
  logic [1:0] pl_sym, maint_sym, rx_sym, tx_sym;
  logic pl_req, tx_frame, tx_superframe, rx_locked, rx_sf_locked, rx_pl_valid;
  logic s_plreq, s_plv;
  int n_chk = 0, n_fail = 0, cnt_plv = 0;
  localparam logic [8:0] SWB = 9'b110001011;

  always #10 clk = ~clk;

  ubr_framer u0 (
    .clk(clk), .rst_n(rst_n), .sym_tick(sym_tick), .nt_mode(nt_mode),
    .pl_sym(pl_sym), .maint_sym(maint_sym), .pl_req(pl_req), .tx_sym(tx_sym),
    .tx_frame(tx_frame), .tx_superframe(tx_superframe), .rx_sym(rx_sym),
    .rx_locked(rx_locked), .rx_sf_locked(rx_sf_locked), .rx_pl_valid(rx_pl_valid)
  );

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] sw_sym(input int p, input bit inv);
    return {SWB[8-p] ^ inv, 1'b0};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; sym_tick = 1'b0; rx_sym = 2'b11; pl_sym = 2'b11; maint_sym = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_tick(input logic [1:0] rs);
    @(negedge clk);
    rx_sym = rs; sym_tick = 1'b1;
    #1;
    s_plreq = pl_req; s_plv = rx_pl_valid;
    if (s_plv) cnt_plv++;
    @(negedge clk);
    sym_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input int f, input bit good);
    for (int p = 0; p < 120; p++)
      do_tick((p < 9 && good) ? sw_sym(p, f == 0) : 2'b11);
  endtask

  task automatic t_reset();
    nt_mode = 1'b0;
    do_reset();
    check("R1 reset outputs", tx_sym == 2'b00 && !tx_frame && !tx_superframe &&
          !rx_locked && !rx_sf_locked && !pl_req, int'(tx_frame), 0);
  endtask

  task automatic t_tx_lt();
    int e_fs = 0, e_sw = 0, e_sf = 0, e_req = 0, e_pl = 0, e_mt = 0, n_req = 0;
    nt_mode = 1'b0;
    do_reset();
    for (int k = 0; k < 1920; k++) begin
      int p = k % 120;
      int f = (k / 120) % 8;
      logic [1:0] pv = 2'(k);
      pl_sym = pv; maint_sym = 2'b01;
      do_tick(2'b11);
      if (k == 0) check("R10 first symbol opens superframe",
                        tx_superframe && tx_sym == 2'b00, int'(tx_sym), 0);
      if (tx_frame != (p == 0)) e_fs++;
      if (tx_superframe != (p == 0 && f == 0)) e_sf++;
      if (p < 9 && tx_sym != sw_sym(p, f == 0)) begin
        if (f == 0) e_sf++; else e_sw++;
      end
      if (s_plreq != (p >= 9 && p < 117)) e_req++;
      if (s_plreq) n_req++;
      if (p >= 9 && p < 117 && tx_sym != pv) e_pl++;
      if (p >= 117 && tx_sym != 2'b01) e_mt++;
    end
    check("R1 frame marker period", e_fs == 0, e_fs, 0);
    check("R2 framing word", e_sw == 0, e_sw, 0);
    check("R3 superframe marker and inverted word", e_sf == 0, e_sf, 0);
    check("R4 request slots", e_req == 0, e_req, 0);
    check("R4 request count", n_req == 16 * 108, n_req, 16 * 108);
    check("R4 payload passthrough", e_pl == 0, e_pl, 0);
    check("R5 maintenance symbols", e_mt == 0, e_mt, 0);
  endtask

  task automatic t_rx();
    nt_mode = 1'b0;
    do_reset();
    for (int i = 0; i < 37; i++) do_tick(2'b11);
    send_frame(3, 1'b1);
    check("R6 one word is not lock", !rx_locked, int'(rx_locked), 0);
    send_frame(4, 1'b1);
    check("R6 lock after two words", rx_locked, int'(rx_locked), 1);
    cnt_plv = 0;
    send_frame(5, 1'b1); send_frame(6, 1'b1); send_frame(7, 1'b1);
    check("R8 no payload before superframe", cnt_plv == 0 && !rx_sf_locked, cnt_plv, 0);
    cnt_plv = 0;
    send_frame(0, 1'b1);
    check("R8 superframe alignment", rx_sf_locked, int'(rx_sf_locked), 1);
    check("R8 payload strobes per frame", cnt_plv == 108, cnt_plv, 108);
    send_frame(1, 1'b0); send_frame(2, 1'b1); send_frame(3, 1'b0); send_frame(4, 1'b0);
    check("R7 hit clears misses, two misses hold", rx_locked, int'(rx_locked), 1);
    send_frame(5, 1'b0);
    check("R7 loss after three misses", !rx_locked, int'(rx_locked), 0);
    check("R8 superframe cleared on loss", !rx_sf_locked, int'(rx_sf_locked), 0);
  endtask

  task automatic t_nt();
    int e_sf = 0, e_w = 0;
    nt_mode = 1'b1;
    do_reset();
    for (int i = 0; i < 53; i++) do_tick(2'b11);
    for (int f = 1; f < 8; f++) send_frame(f, 1'b1);
    for (int f = 0; f < 8; f++) send_frame(f, 1'b1);
    check("R8 aligned before lag test", rx_sf_locked, int'(rx_sf_locked), 1);
    for (int k = 0; k < 960; k++) begin
      int p = k % 120;
      int f = k / 120;
      do_tick((p < 9) ? sw_sym(p, f == 0) : 2'b11);
      if (tx_superframe != (k == 60)) e_sf++;
      if (k >= 60 && k < 69 && tx_sym != sw_sym(k - 60, 1'b1)) e_w++;
    end
    check("R9 transmit superframe lag 60", e_sf == 0, e_sf, 0);
    check("R9 inverted word at lagged start", e_w == 0, e_w, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_tx_lt();
    t_rx();
    t_nt();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule